// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block collects single-cycle event pulses into a 32-bit sticky raw interrupt register. It qualifies that register with a software enable mask and drives one registered interrupt line. Software reads the raw bits, the enable mask and the masked status through a small word-addressed read/write bus. It clears raw bits by writing ones to them.

Two of the raw bits in each direction come from built-in completion coalescers, one for receive and one for transmit. Each coalescer counts completion strobes. It raises a count bit when the completions gathered since its last firing reach a programmable threshold. It raises a timeout bit when completions have been waiting, uncounted, for a programmable number of cycles. Either firing restarts both the count and the timer. Software can therefore trade interrupt rate against completion latency for each direction on its own.

Top module: `irqc_top`

## Requirements
- R1: After reset the raw register (word 0) and the enable register (word 1) read 0 and `irq_o` is low. The threshold register (word 3) reads 0x00010001. The receive timeout (word 4) reads 0x10000 and the transmit timeout (word 5) reads 0x50000.
- R2: A pulse on `evt_i[k]` sets raw bit k at the next clock edge. The bit stays set until software clears it.
- R3: The status register (word 2) reads as the raw register AND the enable register. Raw bits that are not enabled never reach `irq_o`.
- R4: A bus write to word 0 clears each raw bit whose write-data bit is 1 and leaves the other bits unchanged. Writing 0xFFFFFFFF clears every bit.
- R5: When a bit is set by an event or a coalescer firing in the same cycle that a write clears it, the set wins and the bit reads 1 afterwards.
- R6: Receive count coalescing sets raw bit 17 at the edge on which the completion strobes `rx_done_i` counted since the last receive firing reach the threshold in bits 15:0 of word 3. The count then restarts from zero.
- R7: Transmit count coalescing does the same with `tx_done_i`, the threshold in bits 31:16 of word 3, and raw bit 19. It does not affect the receive bits.
- R8: A count threshold of 0 disables count firing for that direction.
- R9: If the receive count threshold is not reached, raw bit 28 sets exactly N clock edges after the edge that registered the first uncounted receive completion, where N is word 4. The timer runs only while completions are pending. N = 0 disables the receive timeout.
- R10: Transmit timeout works the same way, using word 5 and raw bit 29.
- R11: `irq_o` is the OR of all status bits, registered, so it follows a change of the raw or enable register one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Single-cycle event pulses, one per raw bit |
| rx_done_i | input | 1 | Receive completion strobe, one completion per cycle high |
| tx_done_i | input | 1 | Transmit completion strobe, one completion per cycle high |
| bus_sel_i | input | 1 | Bus access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word index: 0 raw, 1 enable, 2 status, 3 thresholds, 4 receive timeout, 5 transmit timeout |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when not reading |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Two functions can land in one cycle: a hardware set of a raw bit (an event pulse or a coalescer firing) and a software write-one-to-clear of that same bit. The bench provokes this by driving an event pulse and a clearing write on the same cycle. It also drives a receive completion that meets a threshold of one together with a write that clears bit 17. After that edge it reads the raw register and expects the bit to still be set. Bits that were only cleared, and that no hardware source set in that cycle, are checked to read 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int NUM_DIR   = 2;
    localparam int TX_TH_LSB = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_RAW   = 3'd0,
        REG_EN    = 3'd1,
        REG_STAT  = 3'd2,
        REG_THR   = 3'd3,
        REG_RXTMO = 3'd4,
        REG_TXTMO = 3'd5
    } reg_idx_e;

    // Raw bit positions of the coalescing sources, indexed by direction (0 rx, 1 tx)
    function automatic int cnt_bit(input int dir);
        return (dir == 0) ? 17 : 19;
    endfunction

    function automatic int tmo_bit(input int dir);
        return (dir == 0) ? 28 : 29;
    endfunction

    function automatic int thr_lsb(input int dir);
        return (dir == 0) ? 0 : TX_TH_LSB;
    endfunction

endpackage

// File: rtl/irqc_coalescer.sv
module irqc_coalescer #(
    parameter int CNT_W = 16,
    parameter int TMO_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             cnt_fire_o,
    output logic             tmo_fire_o
);

    localparam logic [CNT_W-1:0] PEND_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] pend;
        logic [TMO_W-1:0] tmr;
    } coal_state_t;

    coal_state_t st_d, st_q;
    logic [CNT_W-1:0] pend_inc;
    logic             cnt_hit;
    logic             tmo_hit;

    always_comb begin
        st_d     = st_q;
        pend_inc = (st_q.pend == PEND_MAX) ? st_q.pend : st_q.pend + CNT_W'(done_i);
        cnt_hit  = done_i && (thresh_i != '0) && (pend_inc >= thresh_i);
        tmo_hit  = !cnt_hit && (limit_i != '0) && (st_q.pend != '0)
                   && (st_q.tmr >= limit_i - TMO_W'(1));
        if (cnt_hit) begin
            st_d.pend = '0;
            st_d.tmr  = '0;
        end else if (tmo_hit) begin
            st_d.pend = CNT_W'(done_i);
            st_d.tmr  = '0;
        end else begin
            st_d.pend = pend_inc;
            st_d.tmr  = ((limit_i != '0) && (st_q.pend != '0)) ? st_q.tmr + TMO_W'(1) : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_fire_o = cnt_hit;
    assign tmo_fire_o = tmo_hit;

endmodule

// File: rtl/irqc_raw_bank.sv
module irqc_raw_bank #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] en_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] raw;
        logic [W-1:0] en;
        logic         irq;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // set takes precedence over a same-cycle clear
        st_d.raw = (st_q.raw & ~clr_i) | set_i;
        if (en_we_i) st_d.en = en_wdata_i;
        st_d.irq = |(st_q.raw & st_q.en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign raw_o = st_q.raw;
    assign en_o  = st_q.en;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          CNT_W      = 16,
    parameter int          TMO_W      = 24,
    parameter int unsigned RST_RX_TH  = 1,
    parameter int unsigned RST_TX_TH  = 1,
    parameter int unsigned RST_RX_TMO = 32'h0001_0000,
    parameter int unsigned RST_TX_TMO = 32'h0005_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              rx_done_i,
    input  logic              tx_done_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] thr;
        logic [TMO_W-1:0]  rx_tmo;
        logic [TMO_W-1:0]  tx_tmo;
    } cfg_state_t;

    localparam cfg_state_t CFG_RST = '{
        thr:    {16'(RST_TX_TH), 16'(RST_RX_TH)},
        rx_tmo: TMO_W'(RST_RX_TMO),
        tx_tmo: TMO_W'(RST_TX_TMO)
    };

    cfg_state_t cfg_d, cfg_q;

    logic              wr_stb;
    logic              rd_stb;
    reg_idx_e          idx;
    logic [DATA_W-1:0] clr_vec;
    logic              en_we;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] raw_vec;
    logic [DATA_W-1:0] en_vec;

    logic              dir_done  [NUM_DIR];
    logic [TMO_W-1:0]  dir_limit [NUM_DIR];
    logic [DATA_W-1:0] dir_mask  [NUM_DIR];

    assign idx    = reg_idx_e'(bus_addr_i);
    assign wr_stb = bus_sel_i && bus_wr_i;
    assign rd_stb = bus_sel_i && !bus_wr_i;

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (wr_stb) begin
            case (idx)
                REG_THR:   cfg_d.thr    = bus_wdata_i;
                REG_RXTMO: cfg_d.rx_tmo = bus_wdata_i[TMO_W-1:0];
                REG_TXTMO: cfg_d.tx_tmo = bus_wdata_i[TMO_W-1:0];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= CFG_RST;
        else         cfg_q <= cfg_d;
    end

    assign dir_done[0]  = rx_done_i;
    assign dir_done[1]  = tx_done_i;
    assign dir_limit[0] = cfg_q.rx_tmo;
    assign dir_limit[1] = cfg_q.tx_tmo;

    // one coalescer per direction, wired to its own raw bit pair
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam int CB = cnt_bit(d);
        localparam int TB = tmo_bit(d);
        localparam int TL = thr_lsb(d);
        logic cnt_fire;
        logic tmo_fire;

        irqc_coalescer #(
            .CNT_W (CNT_W),
            .TMO_W (TMO_W)
        ) u_coal (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .done_i     (dir_done[d]),
            .thresh_i   (cfg_q.thr[TL +: CNT_W]),
            .limit_i    (dir_limit[d]),
            .cnt_fire_o (cnt_fire),
            .tmo_fire_o (tmo_fire)
        );

        assign dir_mask[d] = (DATA_W'(cnt_fire) << CB) | (DATA_W'(tmo_fire) << TB);
    end

    always_comb begin
        set_vec = evt_i;
        for (int d = 0; d < NUM_DIR; d++) set_vec = set_vec | dir_mask[d];
    end

    assign clr_vec = (wr_stb && idx == REG_RAW) ? bus_wdata_i : '0;
    assign en_we   = wr_stb && idx == REG_EN;

    irqc_raw_bank #(
        .W (DATA_W)
    ) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (set_vec),
        .clr_i      (clr_vec),
        .en_we_i    (en_we),
        .en_wdata_i (bus_wdata_i),
        .raw_o      (raw_vec),
        .en_o       (en_vec),
        .irq_o      (irq_o)
    );

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        if (rd_stb) begin
            case (idx)
                REG_RAW:   bus_rdata_o = raw_vec;
                REG_EN:    bus_rdata_o = en_vec;
                REG_STAT:  bus_rdata_o = raw_vec & en_vec;
                REG_THR:   bus_rdata_o = cfg_q.thr;
                REG_RXTMO: bus_rdata_o = DATA_W'(cfg_q.rx_tmo);
                REG_TXTMO: bus_rdata_o = DATA_W'(cfg_q.tx_tmo);
                default:   bus_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [31:0] evt_i,
    input logic        rx_done_i,
    input logic        tx_done_i,
    input logic        bus_sel_i,
    input logic        bus_wr_i,
    input logic [2:0]  bus_addr_i,
    input logic [31:0] bus_wdata_i,
    input logic [31:0] bus_rdata_o,
    input logic        irq_o,
    input logic [31:0] raw_vec,
    input logic [31:0] en_vec,
    input logic [31:0] set_vec
);

    logic raw_wr;
    assign raw_wr = bus_sel_i && bus_wr_i && (bus_addr_i == 3'd0);

    AST_EVT_SETS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != 32'h0) |=> ((raw_vec & $past(evt_i)) == $past(evt_i))); // R2

    AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_wr_i && bus_addr_i == 3'd2) |-> (bus_rdata_o == (raw_vec & en_vec))); // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raw_wr |=> ((raw_vec & $past(bus_wdata_i & ~set_vec)) == 32'h0)); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raw_wr && ((set_vec & bus_wdata_i) != 32'h0))
        |=> ((raw_vec & $past(set_vec & bus_wdata_i)) == $past(set_vec & bus_wdata_i))); // R5

    AST_RX_CNT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(raw_vec[17]) |-> ($past(rx_done_i) || $past(evt_i[17]))); // R6

    AST_TX_CNT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(raw_vec[19]) |-> ($past(tx_done_i) || $past(evt_i[19]))); // R7

    AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (irq_o == (|($past(raw_vec & en_vec))))); // R11

endmodule

bind irqc_top irqc_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .rx_done_i   (rx_done_i),
    .tx_done_i   (tx_done_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .raw_vec     (raw_vec),
    .en_vec      (en_vec),
    .set_vec     (set_vec)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;
    localparam logic [31:0] B17  = 32'h0002_0000;
    localparam logic [31:0] B19  = 32'h0008_0000;
    localparam logic [31:0] B28  = 32'h1000_0000;
    localparam logic [31:0] B29  = 32'h2000_0000;

    // {event pattern, enable mask}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0001, 32'h0000_0001},
        {32'h8000_0000, 32'h0000_0000},
        {32'h4000_0003, 32'h4000_0001},
        {32'hA5A5_0F0F, 32'hFFFF_0000},
        {32'h0000_0000, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 32'h0F0F_F0F0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] evt;
    logic        rx_done, tx_done;
    logic        sel, wr;
    logic [2:0]  addr;
    logic [31:0] wdata, rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .rx_done_i(rx_done), .tx_done_i(tx_done),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic pulse_evt(input logic [31:0] v);
        evt = v; @(negedge clk); evt = '0;
    endtask

    task automatic pulse_rx();
        rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; evt = '0; rx_done = 0; tx_done = 0;
        sel = 0; wr = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        brd(3'd0, d); chk("R1 raw", d, 32'h0);
        brd(3'd1, d); chk("R1 enable", d, 32'h0);
        brd(3'd3, d); chk("R1 thresholds", d, 32'h0001_0001);
        brd(3'd4, d); chk("R1 rx timeout", d, 32'h0001_0000);
        brd(3'd5, d); chk("R1 tx timeout", d, 32'h0005_0000);
        chk("R1 irq", 32'(irq), 32'h0);

        bwr(3'd4, 32'h0);
        bwr(3'd5, 32'h0);

        // table of event / enable patterns: R2, R3
        for (int i = 0; i < NVEC; i++) begin
            bwr(3'd1, VEC[i][31:0]);
            bwr(3'd0, ONES);
            pulse_evt(VEC[i][63:32]);
            brd(3'd2, d); chk("R3 status", d, VEC[i][63:32] & VEC[i][31:0]);
            brd(3'd0, d); chk("R2 raw", d, VEC[i][63:32]);
        end

        // R2 persistence
        repeat (5) @(negedge clk);
        brd(3'd0, d); chk("R2 sticky", d, ONES);

        // R4 partial and full clear
        bwr(3'd0, 32'h0000_FFFF);
        brd(3'd0, d); chk("R4 partial clear", d, 32'hFFFF_0000);
        bwr(3'd0, ONES);
        brd(3'd0, d); chk("R4 full clear", d, 32'h0);

        // R5 event set and clear in one cycle
        evt = 32'h0000_0008;
        bwr(3'd0, 32'h0000_000C);
        evt = '0;
        brd(3'd0, d); chk("R5 set wins over clear", d, 32'h0000_0008);
        bwr(3'd0, ONES);

        // R11 irq timing
        bwr(3'd1, 32'h0000_0020);
        chk("R11 irq idle", 32'(irq), 32'h0);
        pulse_evt(32'h0000_0020);
        chk("R11 irq lags raw", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R11 irq asserted", 32'(irq), 32'h1);
        bwr(3'd0, 32'h0000_0020);
        chk("R11 irq held one edge after clear", 32'(irq), 32'h1);
        @(negedge clk);
        chk("R11 irq dropped", 32'(irq), 32'h0);

        // R3 masked bit does not raise irq
        pulse_evt(32'h0000_0040);
        repeat (2) @(negedge clk);
        chk("R3 masked no irq", 32'(irq), 32'h0);
        bwr(3'd0, ONES);

        // R6 receive count coalescing
        bwr(3'd3, 32'h0000_0003);
        pulse_rx(); pulse_rx();
        brd(3'd0, d); chk("R6 below threshold", d & B17, 32'h0);
        pulse_rx();
        brd(3'd0, d); chk("R6 threshold reached", d & B17, B17);
        bwr(3'd0, ONES);
        pulse_rx(); pulse_rx();
        brd(3'd0, d); chk("R6 count restarted", d & B17, 32'h0);
        pulse_rx();
        brd(3'd0, d); chk("R6 second firing", d & B17, B17);
        bwr(3'd0, ONES);

        // R8 threshold zero disables
        bwr(3'd3, 32'h0);
        repeat (4) pulse_rx();
        brd(3'd0, d); chk("R8 zero threshold", d & B17, 32'h0);
        bwr(3'd3, 32'h0000_0001);
        pulse_rx();
        bwr(3'd0, ONES);

        // R7 transmit count coalescing
        bwr(3'd3, 32'h0002_0000);
        pulse_tx();
        brd(3'd0, d); chk("R7 below threshold", d & B19, 32'h0);
        pulse_tx();
        brd(3'd0, d); chk("R7 threshold reached", d & (B19 | B17), B19);
        bwr(3'd0, ONES);

        // R9 receive timeout, limit 10
        bwr(3'd3, 32'h0064_0064);
        bwr(3'd4, 32'd10);
        pulse_rx();
        repeat (9) @(negedge clk);
        brd(3'd0, d); chk("R9 before limit", d & B28, 32'h0);
        @(negedge clk);
        brd(3'd0, d); chk("R9 at limit", d & (B28 | B17), B28);
        bwr(3'd4, 32'h0);
        bwr(3'd0, ONES);

        // R10 transmit timeout, limit 6
        bwr(3'd5, 32'd6);
        pulse_tx();
        repeat (5) @(negedge clk);
        brd(3'd0, d); chk("R10 before limit", d & B29, 32'h0);
        @(negedge clk);
        brd(3'd0, d); chk("R10 at limit", d & (B29 | B19), B29);
        bwr(3'd5, 32'h0);
        bwr(3'd0, ONES);

        // R9 zero timeout disables
        pulse_rx();
        repeat (30) @(negedge clk);
        brd(3'd0, d); chk("R9 zero timeout", d & B28, 32'h0);

        // R5 coalescer firing and clear in one cycle
        bwr(3'd3, 32'h0000_0001);
        bwr(3'd0, ONES);
        rx_done = 1'b1;
        bwr(3'd0, B17);
        rx_done = 1'b0;
        brd(3'd0, d); chk("R5 count firing beats clear", d & B17, B17);

        finish_run();
    end

endmodule